// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits next to a processor that runs in its multiprocessor configuration. In that configuration the processor does not drive bus strobes itself. It puts out a 3-bit status code, and the block rebuilds the bus cycle from that code. The bus cycle has four phases, called T1 through T4, with optional wait phases before T4. The block produces the following outputs:

- the address latch strobe;
- the data transceiver enable and direction;
- separate memory and I/O read and write commands, plus early-asserting copies of both write commands;
- the interrupt acknowledge strobe.

A ready input stretches the cycle. A command-enable input, normally held high, gates every command and data-enable output. A strap input changes the meaning of one shared output. With the strap low, that output is a cascade enable for chained interrupt controllers. With the strap high, it is a peripheral data enable for a separate I/O bus. All outputs come from a registered phase and a registered cycle kind, so they change only after a rising clock edge.

Top module: `bus_cmd_gen`

## Requirements
- R1: While reset is asserted, and right after it, the phase is idle. No command or enable is active, `ale` is 0 and `dt_r` equals `IDLE_DIR_HIGH` (1 by default).
- R2: The status codes map to commands as follows. 000 is interrupt acknowledge. 001 is I/O read. 010 is I/O write. 100 (code fetch) and 101 are memory read. 110 is memory write. At most one command kind is active at a time.
- R3: A non-passive code other than 011 seen while idle starts a cycle. `ale` is then high for exactly the one clock of T1. Codes 011 (halt) and 111 (passive) start no cycle.
- R4: From T1 until the cycle ends, `dt_r` is 0 for reads and interrupt acknowledge and 1 for writes. While idle it equals `IDLE_DIR_HIGH`.
- R5: `mem_rd`, `io_rd` and `inta` are active from T2 through T3 and any wait phases. They are inactive in T1 and in T4.
- R6: `mem_wr_adv` and `io_wr_adv` are active from T2. `mem_wr` and `io_wr` are active one clock later, from T3. All of them stay active through the wait phases and clear in T4.
- R7: If `ready` is low at the clock edge that ends T3, wait phases follow. They continue until a clock edge samples `ready` high, and that edge moves the cycle to T4.
- R8: `den` is active during the data phase, which is T2, T3 and the wait phases.
- R9: With `iob_strap` low, `den` covers every cycle kind. `mce_pden` is active during T1 of each interrupt-acknowledge cycle.
- R10: With `iob_strap` high, `den` covers memory cycles only. `mce_pden` is active during the data phase of I/O and interrupt-acknowledge cycles.
- R11: While `cmd_en` is low, every command output, `den` and `mce_pden` is inactive. `ale` and `dt_r` keep their normal behaviour.
- R12: After T4 the block starts no new cycle until the status has been 111. Two interrupt-acknowledge cycles separated by a passive code give two separate `inta` pulses.
- R13: With `CMD_ACTIVE_LOW` = 1, the seven command outputs (`mem_rd`, `mem_wr`, `mem_wr_adv`, `io_rd`, `io_wr`, `io_wr_adv`, `inta`) are driven inverted. All other outputs keep their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status | input | 3 | Bus status code from the processor |
| ready | input | 1 | High ends the cycle's wait phases |
| iob_strap | input | 1 | Selects what `mce_pden` means and which cycles `den` covers |
| cmd_en | input | 1 | Gate for commands and data enables |
| ale | output | 1 | Address latch strobe, high during T1 |
| dt_r | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| den | output | 1 | Data transceiver enable |
| mce_pden | output | 1 | Cascade enable (strap low) or peripheral data enable (strap high) |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_wr_adv | output | 1 | Early memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| io_wr_adv | output | 1 | Early I/O write command |
| inta | output | 1 | Interrupt acknowledge strobe |

## Verification
The bench builds two copies side by side. One uses the default active-high commands. The other sets `CMD_ACTIVE_LOW` to 1, and on every clock its seven command pins must be the exact inverse of the first copy's, which exercises the polarity-selection branch. Both copies keep `IDLE_DIR_HIGH` at 1, so the idle direction level is tested as transmit. With these settings, every cycle kind, both strap settings, the command gate, runs of wait phases and a cycle whose status is held past T4 can each be checked clock by clock.

// File: rtl/bus_cmd_gen_pkg.sv
package bus_cmd_gen_pkg;

   localparam int unsigned STAT_W = 3;
   localparam int unsigned CMD_N  = 7;

   // command vector bit positions
   localparam int unsigned C_MEM_RD  = 0;
   localparam int unsigned C_MEM_WR  = 1;
   localparam int unsigned C_MEM_WRA = 2;
   localparam int unsigned C_IO_RD   = 3;
   localparam int unsigned C_IO_WR   = 4;
   localparam int unsigned C_IO_WRA  = 5;
   localparam int unsigned C_INTA    = 6;

   typedef enum logic [STAT_W-1:0] {
      ST_ACK   = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_PASS  = 3'b111
   } bus_stat_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5,
      PH_END  = 3'd6
   } bus_phase_e;

   typedef struct packed {
      logic mem;
      logic io;
      logic ack;
      logic wr;
   } cyc_kind_t;

endpackage

// File: rtl/bus_cmd_gen_decode.sv
module bus_cmd_gen_decode
   import bus_cmd_gen_pkg::*;
(
   input  logic [STAT_W-1:0] status,
   output logic              start_ok,
   output logic              passive,
   output cyc_kind_t         kind
);

   always_comb begin
      kind     = '0;
      start_ok = 1'b1;
      unique case (bus_stat_e'(status))
         ST_ACK:   kind.ack = 1'b1;
         ST_IORD:  kind.io  = 1'b1;
         ST_IOWR:  begin kind.io  = 1'b1; kind.wr = 1'b1; end
         ST_FETCH: kind.mem = 1'b1;
         ST_MRD:   kind.mem = 1'b1;
         ST_MWR:   begin kind.mem = 1'b1; kind.wr = 1'b1; end
         default:  start_ok = 1'b0;
      endcase
   end

   assign passive = (status == ST_PASS);

endmodule

// File: rtl/bus_cmd_gen_seq.sv
module bus_cmd_gen_seq
   import bus_cmd_gen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_ok,
   input  logic       passive,
   input  cyc_kind_t  kind_in,
   input  logic       ready,
   output bus_phase_e phase,
   output cyc_kind_t  kind_q
);

   bus_phase_e phase_nxt;

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_IDLE: if (start_ok) phase_nxt = PH_T1;
         PH_T1:   phase_nxt = PH_T2;
         PH_T2:   phase_nxt = PH_T3;
         PH_T3:   phase_nxt = ready ? PH_T4 : PH_TW;
         PH_TW:   phase_nxt = ready ? PH_T4 : PH_TW;
         PH_T4:   phase_nxt = passive ? PH_IDLE : PH_END;
         PH_END:  phase_nxt = passive ? PH_IDLE : PH_END;
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         kind_q <= '0;
      end else begin
         phase <= phase_nxt;
         if (phase == PH_IDLE && start_ok)
            kind_q <= kind_in;
      end
   end

endmodule

// File: rtl/bus_cmd_gen_strobe.sv
module bus_cmd_gen_strobe
   import bus_cmd_gen_pkg::*;
#(
   parameter int unsigned CMD_ACTIVE_LOW = 0,
   parameter int unsigned IDLE_DIR_HIGH  = 1
) (
   input  bus_phase_e       phase,
   input  cyc_kind_t        kind,
   input  logic             iob_strap,
   input  logic             cmd_en,
   output logic             ale,
   output logic             dt_r,
   output logic             den,
   output logic             mce_pden,
   output logic [CMD_N-1:0] cmd
);

   localparam logic IDLE_DIR = (IDLE_DIR_HIGH != 0);

   logic             data_ph;
   logic             late_ph;
   logic [CMD_N-1:0] cmd_hi;

   assign data_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
   assign late_ph = (phase == PH_T3) || (phase == PH_TW);

   assign ale  = (phase == PH_T1);
   assign dt_r = (phase == PH_IDLE) ? IDLE_DIR : kind.wr;

   always_comb begin
      cmd_hi            = '0;
      cmd_hi[C_MEM_RD]  = kind.mem & ~kind.wr & data_ph;
      cmd_hi[C_MEM_WRA] = kind.mem &  kind.wr & data_ph;
      cmd_hi[C_MEM_WR]  = kind.mem &  kind.wr & late_ph;
      cmd_hi[C_IO_RD]   = kind.io  & ~kind.wr & data_ph;
      cmd_hi[C_IO_WRA]  = kind.io  &  kind.wr & data_ph;
      cmd_hi[C_IO_WR]   = kind.io  &  kind.wr & late_ph;
      cmd_hi[C_INTA]    = kind.ack & data_ph;
      if (!cmd_en) cmd_hi = '0;
   end

   assign den = cmd_en & data_ph & (~iob_strap | kind.mem);
   assign mce_pden = cmd_en & (iob_strap ? (data_ph & (kind.io | kind.ack))
                                         : ((phase == PH_T1) & kind.ack));

   generate
      if (CMD_ACTIVE_LOW != 0) begin : g_pol_low
         assign cmd = ~cmd_hi;
      end else begin : g_pol_high
         assign cmd = cmd_hi;
      end
   endgenerate

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
   import bus_cmd_gen_pkg::*;
#(
   parameter int unsigned CMD_ACTIVE_LOW = 0,
   parameter int unsigned IDLE_DIR_HIGH  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status,
   input  logic              ready,
   input  logic              iob_strap,
   input  logic              cmd_en,
   output logic              ale,
   output logic              dt_r,
   output logic              den,
   output logic              mce_pden,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_wr_adv,
   output logic              io_rd,
   output logic              io_wr,
   output logic              io_wr_adv,
   output logic              inta
);

   generate
      if (CMD_ACTIVE_LOW > 1) begin : g_bad_pol
         $error("CMD_ACTIVE_LOW must be 0 or 1");
      end
      if (IDLE_DIR_HIGH > 1) begin : g_bad_dir
         $error("IDLE_DIR_HIGH must be 0 or 1");
      end
   endgenerate

   logic             start_ok;
   logic             passive;
   cyc_kind_t        kind_dec;
   cyc_kind_t        kind_q;
   bus_phase_e       phase;
   logic [CMD_N-1:0] cmd;

   bus_cmd_gen_decode u_decode (
      .status   (status),
      .start_ok (start_ok),
      .passive  (passive),
      .kind     (kind_dec)
   );

   bus_cmd_gen_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .passive  (passive),
      .kind_in  (kind_dec),
      .ready    (ready),
      .phase    (phase),
      .kind_q   (kind_q)
   );

   bus_cmd_gen_strobe #(
      .CMD_ACTIVE_LOW (CMD_ACTIVE_LOW),
      .IDLE_DIR_HIGH  (IDLE_DIR_HIGH)
   ) u_strobe (
      .phase     (phase),
      .kind      (kind_q),
      .iob_strap (iob_strap),
      .cmd_en    (cmd_en),
      .ale       (ale),
      .dt_r      (dt_r),
      .den       (den),
      .mce_pden  (mce_pden),
      .cmd       (cmd)
   );

   assign mem_rd     = cmd[C_MEM_RD];
   assign mem_wr     = cmd[C_MEM_WR];
   assign mem_wr_adv = cmd[C_MEM_WRA];
   assign io_rd      = cmd[C_IO_RD];
   assign io_wr      = cmd[C_IO_WR];
   assign io_wr_adv  = cmd[C_IO_WRA];
   assign inta       = cmd[C_INTA];

endmodule

// File: rtl/bus_cmd_gen_chk.sv
module bus_cmd_gen_chk #(
   parameter int unsigned CMD_ACTIVE_LOW = 0
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_en,
   input logic ale,
   input logic dt_r,
   input logic den,
   input logic mce_pden,
   input logic mem_rd,
   input logic mem_wr,
   input logic mem_wr_adv,
   input logic io_rd,
   input logic io_wr,
   input logic io_wr_adv,
   input logic inta
);

   localparam logic INV = (CMD_ACTIVE_LOW != 0);

   logic n_mrd, n_mwr, n_mwra, n_iord, n_iowr, n_iowra, n_inta, any_cmd;

   assign n_mrd   = mem_rd     ^ INV;
   assign n_mwr   = mem_wr     ^ INV;
   assign n_mwra  = mem_wr_adv ^ INV;
   assign n_iord  = io_rd      ^ INV;
   assign n_iowr  = io_wr      ^ INV;
   assign n_iowra = io_wr_adv  ^ INV;
   assign n_inta  = inta       ^ INV;
   assign any_cmd = n_mrd | n_mwr | n_mwra | n_iord | n_iowr | n_iowra | n_inta;

   AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale); // R3
   AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({n_mrd, n_mwra, n_iord, n_iowra, n_inta})); // R2
   AST_NO_CMD_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !any_cmd); // R5
   AST_RD_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (n_mrd | n_iord | n_inta) |-> !dt_r); // R4
   AST_WR_DIR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (n_mwra | n_iowra) |-> dt_r); // R4
   AST_MWR_LAGS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(n_mwr) |-> $past(n_mwra)); // R6
   AST_IOWR_LAGS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(n_iowr) |-> $past(n_iowra)); // R6
   AST_WR_WITHIN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (n_mwr | n_iowr) |-> (n_mwra | n_iowra)); // R6
   AST_CEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_en |-> (!any_cmd && !den && !mce_pden)); // R11

endmodule

bind bus_cmd_gen bus_cmd_gen_chk #(.CMD_ACTIVE_LOW(CMD_ACTIVE_LOW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_en     (cmd_en),
   .ale        (ale),
   .dt_r       (dt_r),
   .den        (den),
   .mce_pden   (mce_pden),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .mem_wr_adv (mem_wr_adv),
   .io_rd      (io_rd),
   .io_wr      (io_wr),
   .io_wr_adv  (io_wr_adv),
   .inta       (inta)
);

// File: tb/bus_cmd_gen_bench.sv
module bus_cmd_gen_bench;

   localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5, P_END = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] status = 3'b111;
   logic       ready = 1'b1;
   logic       iob_strap = 1'b0;
   logic       cmd_en = 1'b1;

   logic ale, dt_r, den, mce_pden, mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv, inta;
   logic ale_i, dt_r_i, den_i, mce_pden_i, mem_rd_i, mem_wr_i, mem_wr_adv_i;
   logic io_rd_i, io_wr_i, io_wr_adv_i, inta_i;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [10:0] q_exp[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   bus_cmd_gen u_bus_cmd_gen (
      .clk(clk), .rst_n(rst_n), .status(status), .ready(ready),
      .iob_strap(iob_strap), .cmd_en(cmd_en),
      .ale(ale), .dt_r(dt_r), .den(den), .mce_pden(mce_pden),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wr_adv(mem_wr_adv),
      .io_rd(io_rd), .io_wr(io_wr), .io_wr_adv(io_wr_adv), .inta(inta)
   );

   bus_cmd_gen #(.CMD_ACTIVE_LOW(1)) u_bus_cmd_gen_inv (
      .clk(clk), .rst_n(rst_n), .status(status), .ready(ready),
      .iob_strap(iob_strap), .cmd_en(cmd_en),
      .ale(ale_i), .dt_r(dt_r_i), .den(den_i), .mce_pden(mce_pden_i),
      .mem_rd(mem_rd_i), .mem_wr(mem_wr_i), .mem_wr_adv(mem_wr_adv_i),
      .io_rd(io_rd_i), .io_wr(io_wr_i), .io_wr_adv(io_wr_adv_i), .inta(inta_i)
   );

   // {ale, dt_r, den, mce_pden, mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv, inta}
   function automatic logic [10:0] model(int ph, logic [2:0] code, logic strap, logic cen);
      logic mem, io, ack, wr, dph, lph;
      logic [10:0] v;
      mem = (code == 3'b100) || (code == 3'b101) || (code == 3'b110);
      io  = (code == 3'b001) || (code == 3'b010);
      ack = (code == 3'b000);
      wr  = (code == 3'b010) || (code == 3'b110);
      dph = (ph == P_T2) || (ph == P_T3) || (ph == P_TW);
      lph = (ph == P_T3) || (ph == P_TW);
      v = '0;
      v[10] = (ph == P_T1);
      v[9]  = (ph == P_IDLE) ? 1'b1 : wr;
      if (cen) begin
         v[8] = dph & (!strap | mem);
         v[7] = strap ? (dph & (io | ack)) : ((ph == P_T1) & ack);
         v[6] = mem & !wr & dph;
         v[5] = mem &  wr & lph;
         v[4] = mem &  wr & dph;
         v[3] = io  & !wr & dph;
         v[2] = io  &  wr & lph;
         v[1] = io  &  wr & dph;
         v[0] = ack & dph;
      end
      return v;
   endfunction

   task automatic step(logic [2:0] st, logic rdy, logic [10:0] e, string tag);
      @(negedge clk);
      status = st;
      ready  = rdy;
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic run_cycle(logic [2:0] code, int waits, logic strap, logic cen,
                            bit end_passive, string tag);
      @(negedge clk);
      iob_strap = strap;
      cmd_en    = cen;
      status    = 3'b111;
      q_exp.push_back(model(P_IDLE, code, strap, cen));
      q_tag.push_back(tag);
      step(code, 1'b1, model(P_T1, code, strap, cen), tag);
      step(code, 1'b1, model(P_T2, code, strap, cen), tag);
      step(code, 1'b1, model(P_T3, code, strap, cen), tag);
      for (int k = 0; k <= waits; k++)
         step(code, (k == waits), model((k < waits) ? P_TW : P_T4, code, strap, cen), tag);
      if (end_passive) begin
         step(3'b111, 1'b1, model(P_IDLE, code, strap, cen), tag);
      end else begin
         step(code, 1'b1, model(P_END, code, strap, cen), tag);
         step(code, 1'b1, model(P_END, code, strap, cen), tag);
         step(3'b111, 1'b1, model(P_IDLE, code, strap, cen), tag);
      end
   endtask

   function automatic logic [10:0] got_main();
      return {ale, dt_r, den, mce_pden, mem_rd, mem_wr, mem_wr_adv, io_rd, io_wr, io_wr_adv, inta};
   endfunction

   function automatic logic [10:0] got_inv();
      return {ale_i, dt_r_i, den_i, mce_pden_i, mem_rd_i, mem_wr_i, mem_wr_adv_i,
              io_rd_i, io_wr_i, io_wr_adv_i, inta_i};
   endfunction

   // monitor: one expected item per clock, sampled 3 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (q_exp.size() > 0) begin
            logic [10:0] e;
            logic [10:0] ei;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_checks++;
            if (got_main() !== e) begin
               n_fail++;
               $display("FAIL %s: outputs %b expected %b", t, got_main(), e);
            end
            ei = e ^ 11'b000_0111_1111;
            n_checks++;
            if (got_inv() !== ei) begin
               n_fail++;
               $display("FAIL R13: inverted copy %b expected %b", got_inv(), ei);
            end
         end
      end
   end

   initial begin
      #500000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      n_checks++;
      if (got_main() !== 11'b010_0000_0000) begin
         n_fail++;
         $display("FAIL R1: reset outputs %b expected %b", got_main(), 11'b010_0000_0000);
      end
      @(negedge clk);
      rst_n = 1'b1;
      q_exp.push_back(model(P_IDLE, 3'b111, 1'b0, 1'b1));
      q_tag.push_back("R1");

      // R3: passive and halt start nothing
      step(3'b111, 1'b1, model(P_IDLE, 3'b111, 1'b0, 1'b1), "R3");
      step(3'b011, 1'b1, model(P_IDLE, 3'b011, 1'b0, 1'b1), "R3");
      step(3'b011, 1'b1, model(P_IDLE, 3'b011, 1'b0, 1'b1), "R3");
      step(3'b111, 1'b1, model(P_IDLE, 3'b111, 1'b0, 1'b1), "R3");

      run_cycle(3'b101, 0, 1'b0, 1'b1, 1'b1, "R5 memory read");
      run_cycle(3'b100, 2, 1'b0, 1'b1, 1'b1, "R7 fetch with waits");
      run_cycle(3'b110, 0, 1'b0, 1'b1, 1'b1, "R6 memory write");
      run_cycle(3'b010, 1, 1'b0, 1'b1, 1'b1, "R6 io write with wait");
      run_cycle(3'b001, 0, 1'b1, 1'b1, 1'b0, "R12 io read held status");
      run_cycle(3'b000, 0, 1'b0, 1'b1, 1'b1, "R9 first acknowledge");
      run_cycle(3'b000, 0, 1'b0, 1'b1, 1'b1, "R12 second acknowledge");
      run_cycle(3'b000, 1, 1'b1, 1'b1, 1'b1, "R10 acknowledge strap high");
      run_cycle(3'b101, 0, 1'b1, 1'b1, 1'b1, "R10 memory read strap high");
      run_cycle(3'b010, 0, 1'b1, 1'b1, 1'b1, "R10 io write strap high");
      run_cycle(3'b110, 1, 1'b0, 1'b0, 1'b1, "R11 gated memory write");
      run_cycle(3'b000, 0, 1'b0, 1'b0, 1'b1, "R11 gated acknowledge");
      run_cycle(3'b001, 3, 1'b0, 1'b1, 1'b1, "R8 io read long wait");
      run_cycle(3'b100, 0, 1'b0, 1'b1, 1'b1, "R4 fetch direction");
      run_cycle(3'b001, 0, 1'b0, 1'b1, 1'b1, "R2 io read");

      while (q_exp.size() > 0) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule